// File: doc/BRIEF.md
# Single-Stream DMA Transfer Engine

This block runs one DMA stream. Software loads an item count, a peripheral address, one or two memory base addresses and a control word, then sets the enable bit. From then on, each request from the peripheral moves exactly one data item. The engine first reads the item from the source over a single-beat request/grant bus port, then writes it to the destination, and finally acknowledges the peripheral. A down-counter of remaining items is visible at the ports, together with half-way, complete and error flags and the currently selected memory buffer.

Three run modes share the same engine. A normal run stops itself once the count reaches zero. A circular run reloads the count and both address pointers and keeps going. A double-buffer run reloads in the same way, but after each completed pass it alternates between two memory bases and pulses a swap strobe. A bus error stops the stream at once. The stream cannot be restarted until software clears the error flag.

Register selector values: 0 control, 1 item count, 2 peripheral address, 3 memory base A, 4 memory base B, 5 flag clear.

Top module: `dma_stream_ctl`

## Requirements
- R1: After reset the stream is off, the remaining count and all three flags are 0, activeBuf is 0 and no bus request is raised.
- R2: Setting the enable bit (control bit 0) leaves the stream off when the programmed item count is zero or when the error flag is set.
- R3: Each accepted peripheral request moves exactly one item. The engine performs a read of the source and then a write of the read word to the destination. perAck pulses in the cycle the write is granted without error, and the remaining count drops by one.
- R4: Control bit 3 selects the direction (0: peripheral to memory, 1: memory to peripheral). Bits [5:4] select the width (0 byte, 1 half-word, 2 and 3 word). The memory pointer steps by 1, 2 or 4 bytes per item when bit 6 is set. The peripheral pointer stays fixed unless bit 7 is set, in which case it steps the same way.
- R5: In normal mode (bits [2:1] = 0 or 3), the stream switches itself off when the remaining count reaches zero and sets the complete flag. An enabled stream never shows a remaining count of zero.
- R6: In circular mode (bits [2:1] = 1), completion sets the complete flag, reloads the remaining count, returns both pointers to their bases and keeps the stream on.
- R7: The half flag sets in the cycle after the item that brings the transferred total to ceil(N/2), where N is the item count. For N = 1 it sets together with the complete flag.
- R8: In double-buffer mode (bits [2:1] = 2), each completion pulses bufSwitch, toggles activeBuf, reloads the count and restarts the memory pointer at the other base (A first, then B).
- R9: A bus error on either phase switches the stream off, sets the error flag, does not decrement the count and does not acknowledge the peripheral.
- R10: While the stream is on, writes to the count, address and control fields are ignored.
- R11: Writing selector 5 clears flags write-one-to-clear (bit 0 half, bit 1 complete, bit 2 error). A flag that sets in the same cycle as its clear stays set.
- R12: Writing control with bit 0 low switches an idle stream off at once. During an item, the switch-off takes effect after that item completes.
- R13: A raised bus request keeps its address and direction until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register selector |
| cfgWdata | input | 32 | Register write data |
| perReq | input | 1 | Peripheral item request |
| perAck | output | 1 | Item accepted, peripheral drops its request |
| busReq | output | 1 | Bus transaction request |
| busWrite | output | 1 | 1 for write, 0 for read |
| busAddr | output | AW | Bus byte address |
| busSize | output | 2 | Item width code |
| busWdata | output | DW | Write data |
| busGnt | input | 1 | Transaction completes this cycle |
| busRdata | input | DW | Read data, valid with busGnt |
| busErr | input | 1 | Transaction failed, valid with busGnt |
| streamOn | output | 1 | Stream enabled |
| remaining | output | CW | Remaining item count |
| halfFlag | output | 1 | Half-way flag |
| doneFlag | output | 1 | Complete flag |
| errFlag | output | 1 | Bus error flag |
| activeBuf | output | 1 | Memory base in use (0 A, 1 B) |
| bufSwitch | output | 1 | Pulse on a double-buffer swap |

## Verification
Two functions can land on the same clock edge. The first pair is a flag being set by the final item and a software write-one-to-clear of that same flag. The second pair is the half-way event and completion when N is 1. The bench provokes both with a bus responder that injects the clear write in exactly the cycle it grants the last write. It then expects both the complete and the half flags to read 1 afterwards. The bench also judges a software switch-off that arrives while a read is still waiting for its grant. The item must finish with one count step and no further bus traffic.

// File: rtl/dma_stream_pkg.sv
`timescale 1ns/1ps
package dma_stream_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_COUNT = 3'd1;
  localparam logic [2:0] REG_PADDR = 3'd2;
  localparam logic [2:0] REG_MBASEA = 3'd3;
  localparam logic [2:0] REG_MBASEB = 3'd4;
  localparam logic [2:0] REG_CLEAR = 3'd5;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CIRC   = 2'd1,
    MODE_DOUBLE = 2'd2
  } xferMode_t;

  typedef enum logic [1:0] {
    ST_OFF, ST_WAIT, ST_READ, ST_WRITE
  } fsmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic capture;
    logic itemDone;
    logic wrap;
    logic writePhase;
    logic cfgLock;
  } dpCtl_t;
endpackage

// File: rtl/dma_stream_dp.sv
`timescale 1ns/1ps
module dma_stream_dp import dma_stream_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgSel,
  input  logic [31:0]   cfgWdata,
  input  dpCtl_t        ctl,
  input  logic [DW-1:0] busRdata,
  output xferMode_t     mode,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busSize,
  output logic [DW-1:0] busWdata,
  output logic [CW-1:0] remaining,
  output logic          activeBuf,
  output logic          cntZero,
  output logic          lastItem,
  output logic          halfHit
);
  logic [CW-1:0] itemCnt, remCnt;
  logic [AW-1:0] perBase, memBaseA, memBaseB, perAddr, memAddr, stepAmt;
  logic [DW-1:0] dataQ;
  logic [1:0]    sizeQ;
  logic          dirQ, memIncQ, perIncQ, bufQ;
  xferMode_t     modeQ;

  assign stepAmt = AW'(1) << sizeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      itemCnt <= '0; remCnt <= '0;
      perBase <= '0; memBaseA <= '0; memBaseB <= '0;
      perAddr <= '0; memAddr <= '0; dataQ <= '0;
      sizeQ <= 2'd0; dirQ <= 1'b0; memIncQ <= 1'b0; perIncQ <= 1'b0;
      bufQ <= 1'b0; modeQ <= MODE_NORMAL;
    end else begin
      if (cfgWe && !ctl.cfgLock) begin
        case (cfgSel)
          REG_CTRL: begin
            modeQ   <= (cfgWdata[2:1] == 2'd1) ? MODE_CIRC :
                       (cfgWdata[2:1] == 2'd2) ? MODE_DOUBLE : MODE_NORMAL;
            dirQ    <= cfgWdata[3];
            sizeQ   <= (cfgWdata[5:4] == 2'd3) ? 2'd2 : cfgWdata[5:4];
            memIncQ <= cfgWdata[6];
            perIncQ <= cfgWdata[7];
          end
          REG_COUNT:  itemCnt  <= CW'(cfgWdata);
          REG_PADDR:  perBase  <= AW'(cfgWdata);
          REG_MBASEA: memBaseA <= AW'(cfgWdata);
          REG_MBASEB: memBaseB <= AW'(cfgWdata);
          default: ;
        endcase
      end
      if (ctl.capture) dataQ <= busRdata;
      if (ctl.start) begin
        remCnt  <= itemCnt;
        perAddr <= perBase;
        memAddr <= memBaseA;
        bufQ    <= 1'b0;
      end else if (ctl.itemDone) begin
        if (ctl.wrap) begin
          remCnt  <= itemCnt;
          perAddr <= perBase;
          if (modeQ == MODE_DOUBLE) begin
            bufQ    <= ~bufQ;
            memAddr <= bufQ ? memBaseA : memBaseB;
          end else begin
            memAddr <= memBaseA;
          end
        end else begin
          remCnt <= remCnt - CW'(1);
          if (memIncQ) memAddr <= memAddr + stepAmt;
          if (perIncQ) perAddr <= perAddr + stepAmt;
        end
      end
    end
  end

  // source is the peripheral unless direction bit is set
  assign busAddr   = (ctl.writePhase ^ dirQ) ? memAddr : perAddr;
  assign busWdata  = dataQ;
  assign busSize   = sizeQ;
  assign mode      = modeQ;
  assign remaining = remCnt;
  assign activeBuf = bufQ;
  assign cntZero   = (itemCnt == '0);
  assign lastItem  = (remCnt == CW'(1));
  assign halfHit   = ((remCnt - CW'(1)) == (itemCnt >> 1));
endmodule

// File: rtl/dma_stream_fsm.sv
`timescale 1ns/1ps
module dma_stream_fsm import dma_stream_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic [2:0] cfgSel,
  input  logic [2:0] cfgLow,
  input  logic      perReq,
  input  logic      busGnt,
  input  logic      busErr,
  input  xferMode_t mode,
  input  logic      cntZero,
  input  logic      lastItem,
  input  logic      halfHit,
  output dpCtl_t    ctl,
  output logic      perAck,
  output logic      busReq,
  output logic      busWrite,
  output logic      streamOn,
  output logic      halfFlag,
  output logic      doneFlag,
  output logic      errFlag,
  output logic      bufSwitch
);
  fsmState_t stateQ, stateD;
  logic stopPend;
  logic ctrlWr, enCmd, offCmd, clrWr, fault, itemOk, finish;

  assign ctrlWr = cfgWe && (cfgSel == REG_CTRL);
  assign enCmd  = ctrlWr && cfgLow[0];
  assign offCmd = ctrlWr && !cfgLow[0];
  assign clrWr  = cfgWe && (cfgSel == REG_CLEAR);
  assign busReq   = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign busWrite = (stateQ == ST_WRITE);
  assign fault  = busReq && busGnt && busErr;
  assign itemOk = (stateQ == ST_WRITE) && busGnt && !busErr;
  assign finish = itemOk && lastItem;

  always_comb begin
    ctl = '0;
    ctl.start      = (stateQ == ST_OFF) && enCmd && !cntZero && !errFlag;
    ctl.capture    = (stateQ == ST_READ) && busGnt && !busErr;
    ctl.itemDone   = itemOk;
    ctl.wrap       = finish && (mode != MODE_NORMAL);
    ctl.writePhase = (stateQ == ST_WRITE);
    ctl.cfgLock    = (stateQ != ST_OFF);
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_OFF:   if (ctl.start) stateD = ST_WAIT;
      ST_WAIT:  if (offCmd) stateD = ST_OFF;
                else if (perReq) stateD = ST_READ;
      ST_READ:  if (fault) stateD = ST_OFF;
                else if (busGnt) stateD = ST_WRITE;
      ST_WRITE: if (fault) stateD = ST_OFF;
                else if (itemOk)
                  stateD = ((finish && mode == MODE_NORMAL) || stopPend || offCmd)
                           ? ST_OFF : ST_WAIT;
      default:  stateD = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OFF; stopPend <= 1'b0;
      halfFlag <= 1'b0; doneFlag <= 1'b0; errFlag <= 1'b0;
    end else begin
      stateQ   <= stateD;
      stopPend <= (stateD == ST_OFF) ? 1'b0 : (stopPend || (offCmd && busReq));
      // a set in the same cycle wins over a clear
      if (itemOk && halfHit)           halfFlag <= 1'b1;
      else if (clrWr && cfgLow[0])     halfFlag <= 1'b0;
      if (finish)                      doneFlag <= 1'b1;
      else if (clrWr && cfgLow[1])     doneFlag <= 1'b0;
      if (fault)                       errFlag  <= 1'b1;
      else if (clrWr && cfgLow[2])     errFlag  <= 1'b0;
    end
  end

  assign perAck    = itemOk;
  assign streamOn  = (stateQ != ST_OFF);
  assign bufSwitch = finish && (mode == MODE_DOUBLE);
endmodule

// File: rtl/dma_stream_ctl.sv
`timescale 1ns/1ps
module dma_stream_ctl import dma_stream_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgSel,
  input  logic [31:0]   cfgWdata,
  input  logic          perReq,
  output logic          perAck,
  output logic          busReq,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busSize,
  output logic [DW-1:0] busWdata,
  input  logic          busGnt,
  input  logic [DW-1:0] busRdata,
  input  logic          busErr,
  output logic          streamOn,
  output logic [CW-1:0] remaining,
  output logic          halfFlag,
  output logic          doneFlag,
  output logic          errFlag,
  output logic          activeBuf,
  output logic          bufSwitch
);
  dpCtl_t    ctl;
  xferMode_t mode;
  logic      cntZero, lastItem, halfHit;

  dma_stream_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgLow(cfgWdata[2:0]),
    .perReq(perReq), .busGnt(busGnt), .busErr(busErr), .mode(mode),
    .cntZero(cntZero), .lastItem(lastItem), .halfHit(halfHit), .ctl(ctl),
    .perAck(perAck), .busReq(busReq), .busWrite(busWrite), .streamOn(streamOn),
    .halfFlag(halfFlag), .doneFlag(doneFlag), .errFlag(errFlag), .bufSwitch(bufSwitch)
  );

  dma_stream_dp #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .ctl(ctl), .busRdata(busRdata), .mode(mode), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .remaining(remaining),
    .activeBuf(activeBuf), .cntZero(cntZero), .lastItem(lastItem), .halfHit(halfHit)
  );
endmodule

// File: rtl/dma_stream_chk.sv
`timescale 1ns/1ps
module dma_stream_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          streamOn,
  input logic          busReq,
  input logic          busWrite,
  input logic          busGnt,
  input logic          busErr,
  input logic [AW-1:0] busAddr,
  input logic          perAck,
  input logic [CW-1:0] remaining,
  input logic          errFlag,
  input logic          doneFlag,
  input logic          activeBuf,
  input logic          bufSwitch
);
  AST_REQ_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> streamOn); // R1
  AST_ACK_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> (busReq && busWrite && busGnt && !busErr)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (perAck && remaining > CW'(1)) |=> (remaining == $past(remaining) - CW'(1))); // R3
  AST_ON_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    streamOn |-> (remaining != '0)); // R5
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busErr) |=> (!streamOn && errFlag)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !streamOn) |=> !streamOn); // R2
  AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    bufSwitch |=> (activeBuf != $past(activeBuf) && doneFlag)); // R8
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> (busReq && $stable(busAddr) && $stable(busWrite))); // R13
endmodule

bind dma_stream_ctl dma_stream_chk #(.AW(AW), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .streamOn(streamOn), .busReq(busReq), .busWrite(busWrite),
  .busGnt(busGnt), .busErr(busErr), .busAddr(busAddr), .perAck(perAck),
  .remaining(remaining), .errFlag(errFlag), .doneFlag(doneFlag),
  .activeBuf(activeBuf), .bufSwitch(bufSwitch)
);

// File: tb/dma_stream_ctl_test.sv
`timescale 1ns/1ps
module dma_stream_ctl_test;
  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
  } txn_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drvWe = 1'b0, hitWe = 1'b0;
  logic [2:0] drvSel = 3'd0;
  logic [31:0] drvData = 32'd0;
  logic cfgWe;
  logic [2:0] cfgSel;
  logic [31:0] cfgWdata;
  logic perReq, perAck, busReq, busWrite, busGnt = 1'b0, busErr = 1'b0;
  logic [31:0] busAddr, busWdata, busRdata = 32'd0;
  logic [1:0] busSize;
  logic streamOn, halfFlag, doneFlag, errFlag, activeBuf, bufSwitch;
  logic [15:0] remaining;

  int nChecks = 0, nErrors = 0;
  int reqIssued = 0, reqServed = 0;
  int gntDelay = 0, waitCnt = 0, swCount = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  bit armClear = 1'b0, finished = 1'b0;
  txn_t expQ[$];

  always #10 clk = ~clk;

  assign cfgWe    = drvWe | hitWe;
  assign cfgSel   = hitWe ? 3'd5 : drvSel;
  assign cfgWdata = hitWe ? 32'h2 : drvData;
  assign perReq   = (reqIssued != reqServed);

  dma_stream_ctl uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .perReq(perReq), .perAck(perAck), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .busGnt(busGnt),
    .busRdata(busRdata), .busErr(busErr), .streamOn(streamOn), .remaining(remaining),
    .halfFlag(halfFlag), .doneFlag(doneFlag), .errFlag(errFlag),
    .activeBuf(activeBuf), .bufSwitch(bufSwitch)
  );

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic expItem(input logic [31:0] src, input logic [31:0] dst);
    expQ.push_back('{1'b0, src, 32'h0});
    expQ.push_back('{1'b1, dst, pattern(src)});
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    drvWe = 1'b1; drvSel = sel; drvData = data;
    @(negedge clk);
    drvWe = 1'b0;
  endtask

  task automatic issue(input int n);
    reqIssued = reqIssued + n;
  endtask

  task automatic waitServed();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (reqIssued == reqServed && !busReq) break;
    end
  endtask

  task automatic waitOff();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!streamOn) break;
    end
  endtask

  // bus responder and scoreboard monitor
  always begin
    @(negedge clk);
    busGnt = 1'b0; busErr = 1'b0; hitWe = 1'b0;
    if (busReq && rstN) begin
      if (waitCnt < gntDelay) waitCnt++;
      else begin
        waitCnt  = 0;
        busGnt   = 1'b1;
        busErr   = (busAddr == errAddr);
        busRdata = pattern(busAddr);
        nChecks++;
        if (expQ.size() == 0) begin
          nErrors++;
          $display("FAIL R3 unexpected bus txn got addr %h exp none", busAddr);
        end else begin
          txn_t e;
          e = expQ.pop_front();
          if (busWrite !== e.wr || busAddr !== e.addr || (e.wr && busWdata !== e.data)) begin
            nErrors++;
            $display("FAIL R4 bus txn got wr=%0b addr=%h data=%h exp wr=%0b addr=%h data=%h",
                     busWrite, busAddr, busWdata, e.wr, e.addr, e.data);
          end
        end
        if (busWrite && !busErr) reqServed++;
        if (armClear && busWrite && remaining == 16'd1) hitWe = 1'b1;
      end
    end else waitCnt = 0;
  end

  always begin
    @(negedge clk);
    #5;
    if (bufSwitch) swCount++;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!streamOn && remaining == 0, "R1 off with zero count", {streamOn, 15'd0, remaining}, 0);
    check(!halfFlag && !doneFlag && !errFlag && !busReq && !activeBuf, "R1 flags clear",
          {halfFlag, doneFlag, errFlag, busReq, activeBuf}, 0);

    // R2 zero count refuses to start
    cfgWrite(3'd0, 32'h61);
    check(!streamOn, "R2 zero count stays off", streamOn, 0);

    // normal mode, word, peripheral to memory, memory increments
    cfgWrite(3'd1, 4); cfgWrite(3'd2, 32'h1000); cfgWrite(3'd3, 32'h2000);
    cfgWrite(3'd0, 32'h61);
    check(streamOn && remaining == 4, "R3 start loads count", remaining, 4);
    for (int i = 0; i < 4; i++) expItem(32'h1000, 32'h2000 + 4 * i);
    issue(1); waitServed();
    check(remaining == 3, "R3 one item per request", remaining, 3);
    check(!halfFlag, "R7 half not yet", halfFlag, 0);
    issue(1); waitServed();
    check(halfFlag && !doneFlag, "R7 half after two of four", {halfFlag, doneFlag}, 2);
    issue(2); waitServed();
    check(!streamOn && remaining == 0 && doneFlag, "R5 normal stops at zero",
          {streamOn, doneFlag, remaining[13:0]}, 32'h4000);

    // R11 selective clear
    cfgWrite(3'd5, 32'h1);
    check(!halfFlag && doneFlag, "R11 clear half only", {halfFlag, doneFlag}, 1);
    cfgWrite(3'd5, 32'h7);

    // circular, half-word, memory to peripheral, both increment
    cfgWrite(3'd1, 3); cfgWrite(3'd2, 32'h3000); cfgWrite(3'd3, 32'h4000);
    cfgWrite(3'd0, 32'hDB);
    cfgWrite(3'd1, 7); cfgWrite(3'd3, 32'h9000); // R10 ignored while on
    for (int i = 0; i < 3; i++) expItem(32'h4000 + 2 * i, 32'h3000 + 2 * i);
    expItem(32'h4000, 32'h3000);
    issue(2); waitServed();
    check(halfFlag && remaining == 1, "R7 half at ceil of three", remaining, 1);
    issue(1); waitServed();
    check(streamOn && doneFlag && remaining == 3, "R6 circular reload (R10 count kept)", remaining, 3);
    issue(1); waitServed();
    check(remaining == 2, "R6 continues after wrap", remaining, 2);
    cfgWrite(3'd0, 32'h0);
    check(!streamOn, "R12 idle switch-off", streamOn, 0);
    cfgWrite(3'd5, 32'h7);

    // double buffer, byte width
    cfgWrite(3'd1, 2); cfgWrite(3'd2, 32'h7000);
    cfgWrite(3'd3, 32'h5000); cfgWrite(3'd4, 32'h6000);
    cfgWrite(3'd0, 32'h45);
    expItem(32'h7000, 32'h5000); expItem(32'h7000, 32'h5001);
    expItem(32'h7000, 32'h6000); expItem(32'h7000, 32'h6001);
    expItem(32'h7000, 32'h5000);
    issue(2); waitServed();
    check(activeBuf && swCount == 1, "R8 first swap to B", {activeBuf, 3'd0, swCount[27:0]}, 32'h1000_0001);
    issue(2); waitServed();
    check(!activeBuf && swCount == 2, "R8 swap back to A", {activeBuf, 3'd0, swCount[27:0]}, 2);
    issue(1); waitServed();
    check(remaining == 1 && streamOn, "R8 keeps running", remaining, 1);
    cfgWrite(3'd0, 32'h0);
    cfgWrite(3'd5, 32'h7);

    // N=1: half and complete together, clear collides with set
    cfgWrite(3'd1, 1); cfgWrite(3'd2, 32'h1100); cfgWrite(3'd3, 32'h2100);
    cfgWrite(3'd0, 32'h61);
    expItem(32'h1100, 32'h2100);
    armClear = 1'b1;
    issue(1); waitServed();
    armClear = 1'b0;
    check(doneFlag, "R11 set beats same-cycle clear", doneFlag, 1);
    check(halfFlag && !streamOn, "R7 half with single item", {halfFlag, streamOn}, 2);
    cfgWrite(3'd5, 32'h7);

    // R9 bus error on the second write
    cfgWrite(3'd1, 3); cfgWrite(3'd2, 32'h1200); cfgWrite(3'd3, 32'h2200);
    cfgWrite(3'd0, 32'h61);
    errAddr = 32'h2204;
    expItem(32'h1200, 32'h2200); expItem(32'h1200, 32'h2204);
    issue(2); waitOff();
    @(negedge clk);
    check(!streamOn && errFlag && remaining == 2, "R9 error stops without step",
          {streamOn, errFlag, remaining[13:0]}, 32'h4002);
    check(reqIssued - reqServed == 1, "R9 no ack for failed item", reqIssued - reqServed, 1);
    reqIssued = reqServed;
    errAddr = 32'hFFFF_FFFF;
    cfgWrite(3'd0, 32'h61);
    check(!streamOn, "R2 error flag blocks enable", streamOn, 0);
    cfgWrite(3'd5, 32'h4);
    cfgWrite(3'd0, 32'h61);
    check(streamOn && remaining == 3, "R9 restart after clear", remaining, 3);

    // R12 switch-off during an item
    gntDelay = 3;
    expItem(32'h1200, 32'h2200);
    issue(1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (busReq) break;
    end
    cfgWrite(3'd0, 32'h0);
    check(streamOn, "R12 item in flight keeps running", streamOn, 1);
    waitOff();
    @(negedge clk);
    check(!streamOn && remaining == 2, "R12 stops after item", {streamOn, 15'd0, remaining}, 2);
    gntDelay = 0;
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3 all expected transactions seen", expQ.size(), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule